// File: doc/BRIEF.md
# Latched one-of-eight decoder and demultiplexer

This block turns a three-bit select code into exactly one active line out of eight. A level-sensitive latch sits in front of the decode. While the hold input is low, the latch passes the select code straight through. While hold is high, the latch keeps the code it had just before hold rose. The decoded outputs then stay fixed while the select bus is free to change.

Two enables of opposite sense gate the outputs after the decode. One is active high and the other active low. Both must be asserted for any line to be active, which lets several blocks be cascaded. To use the block as a demultiplexer, hold one enable in its asserted state and drive a data bit into the other. The selected line then carries that bit.

A parameter fixes, at build time, whether the active line is driven high or low. The enables are not stored: they act on the outputs at once, even while the code is held. An active-low reset clears the stored code to zero so that the outputs are defined from the start.

Top module: `latched_decoder`

## Requirements
- R1: While rst_n is low, the stored code is 0. After rst_n rises with hold high, and before hold has ever been low, the outputs decode code 0.
- R2: While hold is low and both enables are asserted, output bit y[n] is active exactly when sel equals n, with sel[0] as the least significant bit.
- R3: While hold is high, changes on sel have no effect on y. The outputs decode the value sel had in the last cycle that hold was low.
- R4: While en is low, all eight outputs are at their inactive level, whatever hold and sel are.
- R5: While en_n is high, all eight outputs are at their inactive level, whatever hold and sel are.
- R6: With ACTIVE_HIGH=1 the active line is 1 and the other lines are 0. With ACTIVE_HIGH=0 the active line is 0 and the other lines are 1.
- R7: At no time is more than one output line at its active level.
- R8: The enables are not latched. While the code is held, a change on en or en_n shows on y in the same cycle.
- R9: Demultiplexing with en held at 1: the selected line is active exactly when en_n is 0. With en_n held at 0: the selected line is active exactly when en is 1. In both cases the other lines stay inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset. Clears the stored select code to 0. |
| hold | input | 1 | Latch control. Low means transparent, high means the code is held. |
| sel | input | 3 | Select code. Value n picks line n. |
| en | input | 1 | Active-high output enable. |
| en_n | input | 1 | Active-low output enable. |
| y | output | 8 | Decoded lines. The active level is set by ACTIVE_HIGH. |

## Verification
The checker's properties assume that sel and hold never change in the same instant. Otherwise the code captured at the closing edge of the latch would be undefined. The bench therefore changes sel and hold on separate clock edges, and changes any input only half a cycle away from the point where it samples. The block has no clock, so the checker uses immediate assertions on the settled port values. These cover gating, one-hot behaviour, transparency and reset. The retention of a held code over time is left to the bench's reference model, which compares against the model on every clock. Both polarity variants are driven from the same stimulus.

// File: rtl/dec_pkg.sv
package dec_pkg;

   // Upper bound on select width accepted by the library blocks
   localparam int unsigned DEC_MAX_SEL_W = 8;

   // Number of decoded lines for a given select width
   function automatic int unsigned dec_lines(input int unsigned sel_w);
      return 32'd1 << sel_w;
   endfunction

   // Output polarity choice
   typedef enum logic {
      POL_LOW  = 1'b0,
      POL_HIGH = 1'b1
   } dec_pol_e;

endpackage

// File: rtl/dec_addr_latch.sv
module dec_addr_latch #(
   parameter int unsigned SEL_W = 3
) (
   input  logic             rst_n,
   input  logic             hold,
   input  logic [SEL_W-1:0] sel,
   output logic [SEL_W-1:0] code
);

   if (SEL_W < 1 || SEL_W > dec_pkg::DEC_MAX_SEL_W) begin : g_bad_w
      $error("dec_addr_latch: SEL_W out of range");
   end

   logic [SEL_W-1:0] store;

   // Level-sensitive storage: reset wins, transparent while hold is low
   always_latch begin
      if (!rst_n) begin
         store = '0;
      end else if (!hold) begin
         store = sel;
      end
   end

   assign code = store;

endmodule

// File: rtl/dec_onehot.sv
module dec_onehot #(
   parameter int unsigned SEL_W = 3,
   localparam int unsigned N_OUT = dec_pkg::dec_lines(SEL_W)
) (
   input  logic [SEL_W-1:0] code,
   output logic [N_OUT-1:0] hit
);

   for (genvar i = 0; i < N_OUT; i++) begin : g_line
      localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
      assign hit[i] = (code == IDX);
   end

endmodule

// File: rtl/dec_out_stage.sv
module dec_out_stage #(
   parameter int unsigned N_OUT       = 8,
   parameter bit          ACTIVE_HIGH = 1'b1
) (
   input  logic [N_OUT-1:0] hit,
   input  logic             en,
   input  logic             en_n,
   output logic [N_OUT-1:0] y
);

   if (N_OUT < 2) begin : g_bad_n
      $error("dec_out_stage: N_OUT must be at least 2");
   end

   logic             pass;
   logic [N_OUT-1:0] act;

   // Gating sits after the decode and is purely combinational
   assign pass = en & ~en_n;
   assign act  = hit & {N_OUT{pass}};

   if (ACTIVE_HIGH) begin : g_pol_high
      assign y = act;
   end else begin : g_pol_low
      assign y = ~act;
   end

endmodule

// File: rtl/latched_decoder.sv
module latched_decoder #(
   parameter int unsigned SEL_W       = 3,
   parameter bit          ACTIVE_HIGH = 1'b1,
   localparam int unsigned N_OUT      = dec_pkg::dec_lines(SEL_W)
) (
   input  logic             rst_n,
   input  logic             hold,
   input  logic [SEL_W-1:0] sel,
   input  logic             en,
   input  logic             en_n,
   output logic [N_OUT-1:0] y
);

   if (SEL_W < 1 || SEL_W > dec_pkg::DEC_MAX_SEL_W) begin : g_bad_w
      $error("latched_decoder: SEL_W out of range");
   end

   logic [SEL_W-1:0] code;
   logic [N_OUT-1:0] hit;

   dec_addr_latch #(.SEL_W(SEL_W)) u_latch (
      .rst_n (rst_n),
      .hold  (hold),
      .sel   (sel),
      .code  (code)
   );

   dec_onehot #(.SEL_W(SEL_W)) u_dec (
      .code (code),
      .hit  (hit)
   );

   dec_out_stage #(.N_OUT(N_OUT), .ACTIVE_HIGH(ACTIVE_HIGH)) u_out (
      .hit  (hit),
      .en   (en),
      .en_n (en_n),
      .y    (y)
   );

endmodule

// File: rtl/latched_decoder_chk.sv
module latched_decoder_chk #(
   parameter int unsigned SEL_W       = 3,
   parameter bit          ACTIVE_HIGH = 1'b1,
   localparam int unsigned N_OUT      = dec_pkg::dec_lines(SEL_W)
) (
   input logic             rst_n,
   input logic             hold,
   input logic [SEL_W-1:0] sel,
   input logic             en,
   input logic             en_n,
   input logic [N_OUT-1:0] y
);

   logic [N_OUT-1:0] act;
   logic             on;

   assign act = ACTIVE_HIGH ? y : ~y;
   assign on  = en & ~en_n;

   always_comb begin
      AST_AT_MOST_ONE: assert ($countones(act) <= 1);                    // R7
      if (!en) begin
         AST_EN_OFF: assert (act == '0);                                 // R4
      end
      if (en_n) begin
         AST_EN_N_OFF: assert (act == '0);                               // R5
      end
      if (on) begin
         AST_ON_ONE_LINE: assert ($countones(act) == 1);                 // R8
      end
      if (rst_n && !hold && on) begin
         AST_TRANSPARENT: assert (act[sel]);                             // R2
      end
      if (!rst_n && on) begin
         AST_RESET_ZERO: assert (act[0]);                                // R1
      end
   end

endmodule

bind latched_decoder latched_decoder_chk #(
   .SEL_W       (SEL_W),
   .ACTIVE_HIGH (ACTIVE_HIGH)
) u_chk (
   .rst_n (rst_n),
   .hold  (hold),
   .sel   (sel),
   .en    (en),
   .en_n  (en_n),
   .y     (y)
);

// File: tb/test_latched_decoder.sv
module test_latched_decoder;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       hold;
   logic [2:0] sel;
   logic       en;
   logic       en_n;
   logic [7:0] y_hi;
   logic [7:0] y_lo;

   int    checks = 0;
   int    errors = 0;
   int    ref_code = 0;
   bit    done = 1'b0;
   string req = "R1";

   always #2.5 clk = ~clk;

   latched_decoder #(.SEL_W(3), .ACTIVE_HIGH(1'b1)) i_latched_decoder (
      .rst_n (rst_n), .hold (hold), .sel (sel), .en (en), .en_n (en_n), .y (y_hi)
   );

   latched_decoder #(.SEL_W(3), .ACTIVE_HIGH(1'b0)) i_latched_decoder_lo (
      .rst_n (rst_n), .hold (hold), .sel (sel), .en (en), .en_n (en_n), .y (y_lo)
   );

   // Behavioural reference model, evaluated and compared on every falling edge
   always @(negedge clk) begin
      logic [7:0] exp_hi;
      if (!rst_n)     ref_code = 0;
      else if (!hold) ref_code = int'(sel);
      exp_hi = (en && !en_n) ? 8'(1 << ref_code) : 8'h00;
      checks++;
      if (y_hi !== exp_hi) begin
         errors++;
         $display("FAIL %s R6 high variant: actual %b expected %b", req, y_hi, exp_hi);
      end
      checks++;
      if (y_lo !== ~exp_hi) begin
         errors++;
         $display("FAIL %s R6 low variant: actual %b expected %b", req, y_lo, ~exp_hi);
      end
      checks++;
      if ($countones(y_hi) > 1 || $countones(~y_lo) > 1) begin
         errors++;
         $display("FAIL R7 one-hot: actual hi %b lo %b expected at most one active", y_hi, y_lo);
      end
   end

   task automatic drive(input logic r, input logic h, input logic [2:0] s,
                        input logic e, input logic en_b);
      @(posedge clk);
      rst_n = r; hold = h; sel = s; en = e; en_n = en_b;
   endtask

   initial begin
      rst_n = 1'b0; hold = 1'b1; sel = 3'd5; en = 1'b1; en_n = 1'b0;
      // R1: reset clears stored code, held through release
      req = "R1";
      repeat (3) drive(1'b0, 1'b1, 3'd5, 1'b1, 1'b0);
      drive(1'b1, 1'b1, 3'd5, 1'b1, 1'b0);
      drive(1'b1, 1'b1, 3'd2, 1'b1, 1'b0);
      // R2 R6: transparent decode of every code
      req = "R2";
      for (int i = 0; i < 8; i++) drive(1'b1, 1'b0, 3'(i), 1'b1, 1'b0);
      // R3: hold captures 6, later sel changes ignored
      req = "R3";
      drive(1'b1, 1'b0, 3'd6, 1'b1, 1'b0);
      drive(1'b1, 1'b1, 3'd6, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) drive(1'b1, 1'b1, 3'(i), 1'b1, 1'b0);
      // R8: enables act at once while held
      req = "R8";
      for (int k = 0; k < 4; k++) drive(1'b1, 1'b1, 3'd1, k[0], k[1]);
      drive(1'b1, 1'b1, 3'd3, 1'b1, 1'b0);
      // R4 R5: every enable combination over every code, transparent
      req = "R4 R5";
      for (int i = 0; i < 8; i++)
         for (int k = 0; k < 4; k++) drive(1'b1, 1'b0, 3'(i), k[0], k[1]);
      // R9: data on en_n, then data on en
      req = "R9";
      for (int i = 0; i < 8; i++) begin
         drive(1'b1, 1'b0, 3'(i), 1'b1, 1'b0);
         drive(1'b1, 1'b0, 3'(i), 1'b1, 1'b1);
         drive(1'b1, 1'b0, 3'(i), 1'b1, 1'b0);
         drive(1'b1, 1'b0, 3'(i), 1'b0, 1'b0);
         drive(1'b1, 1'b0, 3'(i), 1'b1, 1'b0);
      end
      // R1: reset again while holding a nonzero code
      req = "R1";
      drive(1'b1, 1'b1, 3'd7, 1'b1, 1'b0);
      drive(1'b0, 1'b1, 3'd7, 1'b1, 1'b0);
      drive(1'b1, 1'b1, 3'd7, 1'b1, 1'b0);
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule